// File: doc/BRIEF.md
# Shared-Word Contention Arbiter

This block sits in front of a shared 8K x 16 two-port memory and watches the left and right access ports. When both ports are selected and present the same 13-bit word address, it awards the word to exactly one of them. It pulls the other port's active-low busy flag low, so that port holds its cycle until the winner is done. It also produces a gated write enable per port, so a write from a port that is told to wait never reaches the array. The memory array itself is not part of the block.

The model is synchronous. Arrival order is judged by the clock cycle in which a port's select or address change is first seen, against registered copies of each port's previous select and address. Two conflict cases are handled. If the addresses already matched and the selects went active at different times, the earlier select wins. If both selects were already active and an address move creates the match, the port whose address had settled first wins. A same-cycle tie goes to the left port.

For width expansion, a mode input lets several copies share one arbitration decision. In slave mode the block does no arbitration of its own. It takes busy from a master through two inputs and uses those inputs only to block writes.

Top module: `shared_word_arbiter`

## Requirements
- R1: In master mode, when the ports are not both selected, or their addresses differ, both busy outputs are high and each port's write enable equals (select active AND write request).
- R2: When both ports present the same address and the left select becomes active in an earlier cycle than the right, the right busy output goes low in the cycle the right select becomes active, and the left busy stays high. The mirrored order makes the left port lose.
- R3: When both selects are already active and one port moves its address onto the address the other port already held, the port that moved loses, and its busy output is low in that same cycle.
- R4: When both ports become eligible for the same word in the same cycle, through simultaneous selects or simultaneous address moves, the left port wins. The two busy outputs are never low together.
- R5: The loser's busy output stays low for as long as the winner remains selected on the matching address, even if the winner's write request changes. It returns high in the cycle the winner deselects or moves its address away. If the released winner then comes back, it is treated as the later arrival.
- R6: A port whose busy output is low has its write enable forced low. The winner's write request passes unchanged.
- R7: In slave mode (mode input low), both busy outputs stay high even on an address match. A low busy input blocks that port's writes and nothing else; a high busy input lets a selected write pass.
- R8: While the synchronised reset is active, both busy outputs are high, both write enables are low and no grant is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| master_mode | input | 1 | 1 = arbitrate internally, 0 = take busy from inputs |
| l_cs_n | input | 1 | Left port select, active low |
| l_addr | input | 13 | Left port word address |
| l_wr | input | 1 | Left port write request |
| r_cs_n | input | 1 | Right port select, active low |
| r_addr | input | 13 | Right port word address |
| r_wr | input | 1 | Right port write request |
| l_busy_in_n | input | 1 | Slave mode: external busy for the left port, active low |
| r_busy_in_n | input | 1 | Slave mode: external busy for the right port, active low |
| l_busy_n | output | 1 | Busy flag to the left port, active low |
| r_busy_n | output | 1 | Busy flag to the right port, active low |
| l_wr_ok | output | 1 | Left write enable after inhibition |
| r_wr_ok | output | 1 | Right write enable after inhibition |

## Verification
The busy flags and write enables are combinational from the live inputs and one cycle of registered history, so a fault shows up in the same cycle as the stimulus. A stale previous-select or previous-address register inverts the winner in the first conflict cycle. A grant register that fails to hold shows up one cycle later, when the busy flag jumps to the other port while both addresses stay fixed. A leaked write appears as a write enable that is high while the same port's busy flag is low.

// File: rtl/swa_pkg.sv
package swa_pkg;
  localparam int unsigned SWA_ADDR_W = 13;
  localparam int unsigned SWA_NPORT  = 2;
  localparam int unsigned SWA_LEFT   = 0;
  localparam int unsigned SWA_RIGHT  = 1;

  typedef enum logic [1:0] {
    GR_NONE  = 2'd0,
    GR_LEFT  = 2'd1,
    GR_RIGHT = 2'd2
  } grant_e;
endpackage

// File: rtl/swa_port_track.sv
// Keeps one cycle of history for a port and flags a "fresh" arrival:
// the port is selected now and was either unselected or on another
// address in the previous cycle.
module swa_port_track #(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_ok_n,
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  output logic              fresh
);
  logic              sel_q, sel_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              hist_en;

  always_comb begin
    hist_en = 1'b1;
    sel_d   = sel;
    addr_d  = addr;
    fresh   = sel && (!sel_q || (addr != addr_q));
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      sel_q  <= 1'b0;
      addr_q <= '0;
    end else if (hist_en) begin
      sel_q  <= sel_d;
      addr_q <= addr_d;
    end
  end

  // a port that was unselected last cycle must be seen as fresh now
  AST_UNSEL_THEN_FRESH: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!sel ##1 sel) |-> fresh); // R2
endmodule

// File: rtl/swa_grant_fsm.sv
// Detects a shared-word match and decides / holds the winner.
module swa_grant_fsm
  import swa_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_ok_n,
  input  logic [1:0]        sel,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic [1:0]        fresh,
  output logic              match,
  output logic [1:0]        lose
);
  grant_e grant_q, grant_d;
  logic   pick_right;
  logic   eff_right;
  logic   grant_en;

  always_comb begin
    match      = sel[SWA_LEFT] && sel[SWA_RIGHT] && (addr_l == addr_r);
    // right wins only when left is the later arrival and right is not
    pick_right = fresh[SWA_LEFT] && !fresh[SWA_RIGHT];
    if (grant_q == GR_NONE) eff_right = pick_right;
    else                    eff_right = (grant_q == GR_RIGHT);
    lose[SWA_LEFT]  = match && eff_right;
    lose[SWA_RIGHT] = match && !eff_right;
  end

  always_comb begin
    grant_d = grant_q;
    if (!match)                 grant_d = GR_NONE;
    else if (grant_q == GR_NONE) grant_d = pick_right ? GR_RIGHT : GR_LEFT;
    grant_en = (grant_d != grant_q);
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n)     grant_q <= GR_NONE;
    else if (grant_en) grant_q <= grant_d;
  end

  AST_HOLD_LEFT: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (grant_q == GR_LEFT && match) |=> (grant_q == GR_LEFT)); // R5
  AST_HOLD_RIGHT: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (grant_q == GR_RIGHT && match) |=> (grant_q == GR_RIGHT)); // R5
  AST_SINGLE_LOSER: assert property (@(posedge clk) disable iff (!rst_ok_n)
    $countones(lose) <= 1); // R4
endmodule

// File: rtl/swa_port_gate.sv
// Per-port busy output and write inhibition.
module swa_port_gate (
  input  logic clk,
  input  logic rst_ok_n,
  input  logic master,
  input  logic sel,
  input  logic wr,
  input  logic lose,
  input  logic busy_in_n,
  output logic busy_n,
  output logic wr_ok
);
  logic blocked;

  always_comb begin
    busy_n  = !(rst_ok_n && master && lose);
    blocked = master ? lose : !busy_in_n;
    wr_ok   = rst_ok_n && sel && wr && !blocked;
  end

  AST_BUSY_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !busy_n |-> !wr_ok); // R6
  AST_SLAVE_INPUT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!master && !busy_in_n) |-> !wr_ok); // R7
  AST_SLAVE_NO_BUSY_OUT: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !master |-> busy_n); // R7
endmodule

// File: rtl/shared_word_arbiter.sv
module shared_word_arbiter
  import swa_pkg::*;
#(
  parameter int unsigned ADDR_W = SWA_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_cs_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wr,
  input  logic              r_cs_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wr,
  input  logic              l_busy_in_n,
  input  logic              r_busy_in_n,
  output logic              l_busy_n,
  output logic              r_busy_n,
  output logic              l_wr_ok,
  output logic              r_wr_ok
);
  localparam int unsigned NP = SWA_NPORT;

  logic [1:0]             rst_pipe_q;
  logic                   rst_ok_n;
  logic [NP-1:0]          sel, wr, fresh, lose, busy_in_n, busy_n, wr_ok;
  logic [NP-1:0][ADDR_W-1:0] addr;
  logic                   match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ok_n = rst_pipe_q[1];

  always_comb begin
    sel[SWA_LEFT]        = !l_cs_n;
    sel[SWA_RIGHT]       = !r_cs_n;
    addr[SWA_LEFT]       = l_addr;
    addr[SWA_RIGHT]      = r_addr;
    wr[SWA_LEFT]         = l_wr;
    wr[SWA_RIGHT]        = r_wr;
    busy_in_n[SWA_LEFT]  = l_busy_in_n;
    busy_in_n[SWA_RIGHT] = r_busy_in_n;
  end

  for (genvar p = 0; p < NP; p++) begin : g_port
    swa_port_track #(.ADDR_W(ADDR_W)) u_track (
      .clk      (clk),
      .rst_ok_n (rst_ok_n),
      .sel      (sel[p]),
      .addr     (addr[p]),
      .fresh    (fresh[p])
    );
    swa_port_gate u_gate (
      .clk       (clk),
      .rst_ok_n  (rst_ok_n),
      .master    (master_mode),
      .sel       (sel[p]),
      .wr        (wr[p]),
      .lose      (lose[p]),
      .busy_in_n (busy_in_n[p]),
      .busy_n    (busy_n[p]),
      .wr_ok     (wr_ok[p])
    );
  end

  swa_grant_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk      (clk),
    .rst_ok_n (rst_ok_n),
    .sel      (sel),
    .addr_l   (addr[SWA_LEFT]),
    .addr_r   (addr[SWA_RIGHT]),
    .fresh    (fresh),
    .match    (match),
    .lose     (lose)
  );

  assign l_busy_n = busy_n[SWA_LEFT];
  assign r_busy_n = busy_n[SWA_RIGHT];
  assign l_wr_ok  = wr_ok[SWA_LEFT];
  assign r_wr_ok  = wr_ok[SWA_RIGHT];

  AST_NO_MATCH_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !match |-> (l_busy_n && r_busy_n)); // R1
  AST_NEVER_BOTH_BUSY: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (l_busy_n || r_busy_n)); // R4
  AST_LEFT_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !l_busy_n |-> !l_wr_ok); // R6
  AST_RIGHT_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !r_busy_n |-> !r_wr_ok); // R6
endmodule

// File: tb/shared_word_arbiter_test.sv
`timescale 1ns/1ps
module shared_word_arbiter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        master_mode;
  logic        l_cs_n, r_cs_n, l_wr, r_wr, l_busy_in_n, r_busy_in_n;
  logic [12:0] l_addr, r_addr;
  logic        l_busy_n, r_busy_n, l_wr_ok, r_wr_ok;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  shared_word_arbiter uut (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_cs_n(l_cs_n), .l_addr(l_addr), .l_wr(l_wr),
    .r_cs_n(r_cs_n), .r_addr(r_addr), .r_wr(r_wr),
    .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
    .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
    .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok)
  );

  // apply inputs just after a falling edge; outputs settle before the next rise
  task automatic drv(input logic lc, input logic [12:0] la, input logic lw,
                     input logic rc, input logic [12:0] ra, input logic rw);
    @(negedge clk);
    l_cs_n = lc; l_addr = la; l_wr = lw;
    r_cs_n = rc; r_addr = ra; r_wr = rw;
    #1;
  endtask

  task automatic idle();
    drv(1'b1, 13'h0, 1'b0, 1'b1, 13'h0, 1'b0);
  endtask

  // expected order: {l_busy_n, r_busy_n, l_wr_ok, r_wr_ok}
  task automatic chk(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {l_busy_n, r_busy_n, l_wr_ok, r_wr_ok};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    drv(1'b0, 13'h0AA, 1'b1, 1'b0, 13'h0AA, 1'b1);
    chk("R8 in reset, matched writes", 4'b1100);
    @(negedge clk); rst_n = 1'b1;
    idle(); idle(); idle();
    chk("R8 after reset idle", 4'b1100);
  endtask

  task automatic t_no_conflict();
    idle();
    drv(1'b0, 13'h010, 1'b1, 1'b0, 13'h011, 1'b1);
    chk("R1 different addresses", 4'b1111);
    drv(1'b0, 13'h011, 1'b1, 1'b1, 13'h011, 1'b1);
    chk("R1 right deselected same address", 4'b1110);
  endtask

  task automatic t_cs_order();
    idle();
    drv(1'b0, 13'h0AB, 1'b0, 1'b1, 13'h0AB, 1'b0);
    chk("R2 left selected alone", 4'b1100);
    drv(1'b0, 13'h0AB, 1'b0, 1'b0, 13'h0AB, 1'b0);
    chk("R2 left selected first wins", 4'b1000);
    drv(1'b0, 13'h0AB, 1'b1, 1'b0, 13'h0AB, 1'b1);
    chk("R6 loser write held, winner passes", 4'b1010);
    idle();
    drv(1'b1, 13'h1C0, 1'b0, 1'b0, 13'h1C0, 1'b1);
    drv(1'b0, 13'h1C0, 1'b1, 1'b0, 13'h1C0, 1'b1);
    chk("R2 right selected first wins", 4'b0101);
  endtask

  task automatic t_addr_order();
    idle();
    drv(1'b0, 13'h100, 1'b0, 1'b0, 13'h1FF, 1'b0);
    chk("R1 both selected apart", 4'b1100);
    drv(1'b0, 13'h1FF, 1'b0, 1'b0, 13'h1FF, 1'b0);
    chk("R3 left moved onto right, right wins", 4'b0100);
    idle();
    drv(1'b0, 13'h0F0, 1'b0, 1'b0, 13'h055, 1'b0);
    drv(1'b0, 13'h0F0, 1'b0, 1'b0, 13'h0F0, 1'b1);
    chk("R3 right moved onto left, left wins", 4'b1000);
  endtask

  task automatic t_tie();
    idle();
    drv(1'b0, 13'h1FFE, 1'b1, 1'b0, 13'h1FFE, 1'b1);
    chk("R4 same-cycle select tie to left", 4'b1010);
    idle();
    drv(1'b0, 13'h010, 1'b0, 1'b0, 13'h020, 1'b0);
    drv(1'b0, 13'h333, 1'b0, 1'b0, 13'h333, 1'b0);
    chk("R4 same-cycle address tie to left", 4'b1000);
  endtask

  task automatic t_hold_release();
    idle();
    drv(1'b0, 13'h1FFE, 1'b1, 1'b0, 13'h1FFE, 1'b1);
    drv(1'b0, 13'h1FFE, 1'b0, 1'b0, 13'h1FFE, 1'b1);
    chk("R5 held while winner stays", 4'b1000);
    drv(1'b0, 13'h1FFE, 1'b1, 1'b0, 13'h1FFE, 1'b1);
    chk("R5 held with winner writing", 4'b1010);
    drv(1'b1, 13'h1FFE, 1'b1, 1'b0, 13'h1FFE, 1'b1);
    chk("R5 released on winner deselect", 4'b1101);
    drv(1'b0, 13'h1FFE, 1'b1, 1'b0, 13'h1FFE, 1'b1);
    chk("R5 returning port is later arrival", 4'b0101);
    drv(1'b0, 13'h1FFE, 1'b1, 1'b0, 13'h0000, 1'b1);
    chk("R5 released on winner address move", 4'b1111);
  endtask

  task automatic t_slave();
    idle();
    master_mode = 1'b0;
    drv(1'b0, 13'h042, 1'b1, 1'b0, 13'h042, 1'b1);
    chk("R7 slave match, no busy out", 4'b1111);
    @(negedge clk); l_busy_in_n = 1'b0; #1;
    chk("R7 slave left busy in blocks left write", 4'b1101);
    @(negedge clk); l_busy_in_n = 1'b1; r_busy_in_n = 1'b0; #1;
    chk("R7 slave right busy in blocks right write", 4'b1110);
    @(negedge clk); r_busy_in_n = 1'b1; #1;
    drv(1'b1, 13'h042, 1'b1, 1'b0, 13'h042, 1'b1);
    chk("R7 slave deselected left no write", 4'b1101);
    idle();
    master_mode = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; master_mode = 1'b1;
    l_cs_n = 1'b1; r_cs_n = 1'b1; l_wr = 1'b0; r_wr = 1'b0;
    l_addr = '0; r_addr = '0; l_busy_in_n = 1'b1; r_busy_in_n = 1'b1;
    t_reset();
    t_no_conflict();
    t_cs_order();
    t_addr_order();
    t_tie();
    t_hold_release();
    t_slave();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule